// File: doc/BRIEF.md
# Bridge Quiesce and Reset Sequencer

This block steps one sub-block of an island that is already powered through its bring-up and shut-down. It owns four controls: the sub-block clock enable, an active-low reset, and a stop request for each of two asynchronous bus bridges (the master-side bridge and the slave-side bridge). Each bridge returns an acknowledge. The acknowledge is high when the bridge has stopped and low when it is running. The sequencer waits on the acknowledges and ends every request with a one-cycle `done_o` or a one-cycle `err_o`.

Enable brings the clock up for a fixed hold window so the reset can reach every flop. It then gates the clock, releases the reset, turns the clock back on, starts the master bridge and then the slave bridge. Disable runs in the opposite direction: it stops the slave bridge, then the master bridge, then gates the clock, then asserts reset. A reset pulse is a complete disable followed by a complete enable. It is accepted only while the parent island reports power. A step that fails is unwound, so the sub-block is never left half started.

Every wait on an acknowledge is bounded by `ACK_WAIT` cycles. The default of 250 cycles equals 1 µs at 250 MHz. A constant identification word is also presented on its own output.

Top module: `bridge_seq`

## Requirements
- R1: After reset, `clk_en_o`=0, `blk_rst_n_o`=0, `mst_stop_o`=1, `slv_stop_o`=1, `busy_o`=0 and `rst_status_o`=1.
- R2: Enable holds `clk_en_o` high for exactly `HOLD_CYCLES` cycles and then gates it. The reset is released and the clock turned on again. `mst_stop_o` then falls, and `slv_stop_o` falls only after `mst_ack` is seen low. When `slv_ack` is seen low, `done_o` pulses and the outputs are clk_en=1, rst_n=1, mst_stop=0, slv_stop=0.
- R3: `blk_rst_n_o` rises only while `clk_en_o` is low.
- R4: If `mst_ack` does not go low within `ACK_WAIT` cycles during enable, the clock is gated, reset is reasserted and `err_o` pulses. `mst_stop_o` stays 0 and `slv_stop_o` stays 1.
- R5: If `slv_ack` does not go low during enable, `mst_stop_o` is set again. Once `mst_ack` is high, or after a further timeout, the clock is gated, reset is reasserted and `err_o` pulses.
- R6: Disable sets `slv_stop_o` and waits for `slv_ack` high. It then sets `mst_stop_o` and waits for `mst_ack` high, then gates the clock, then asserts reset on the following cycle, and then pulses `done_o`.
- R7: If `slv_ack` does not rise during disable, `err_o` pulses. The master bridge, the clock and the reset are left unchanged.
- R8: If `mst_ack` does not rise during disable, `slv_stop_o` is cleared again and `err_o` pulses. The clock and the reset are left unchanged.
- R9: A reset pulse with `island_up`=1 runs the full disable sequence and then the full enable sequence. Reset goes low during the pulse, and exactly one `done_o` is issued, at the end.
- R10: A reset pulse with `island_up`=0 changes no output and pulses `err_o` on the cycle after the request.
- R11: Requests are ignored while `busy_o` is high. When requests coincide in idle, the priority order is reset, then disable, then enable.
- R12: `id_o` is always 0x62726467, and `rst_status_o` is high exactly when `blk_rst_n_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset of the sequencer |
| island_up | input | 1 | Parent power island is up |
| req_enable | input | 1 | Start the enable sequence (sampled in idle) |
| req_disable | input | 1 | Start the disable sequence (sampled in idle) |
| req_reset | input | 1 | Start a reset pulse (sampled in idle) |
| mst_ack | input | 1 | Master bridge acknowledge, high when stopped |
| slv_ack | input | 1 | Slave bridge acknowledge, high when stopped |
| clk_en_o | output | 1 | Sub-block clock enable |
| blk_rst_n_o | output | 1 | Sub-block active-low reset |
| mst_stop_o | output | 1 | Master bridge stop request |
| slv_stop_o | output | 1 | Slave bridge stop request |
| busy_o | output | 1 | A sequence is in progress |
| done_o | output | 1 | One-cycle pulse: sequence completed |
| err_o | output | 1 | One-cycle pulse: sequence failed or was refused |
| rst_status_o | output | 1 | High while the sub-block is held in reset |
| id_o | output | 32 | Constant identification word |

## Verification
A request is sampled on a rising edge, and the first output of its sequence changes on that same edge. A refused reset pulse therefore shows `err_o` on the falling edge just after the request is taken. The enable hold window is counted on falling edges starting at the first one after the request, and it must be exactly `HOLD_CYCLES` samples long. All results that follow depend on acknowledge latencies, so the bench does not predict a fixed cycle for them. It polls on each falling edge until `done_o` or `err_o` appears, and only then compares the four control outputs. Ordering is checked by recording the falling-edge index at which each control first changes and comparing those indices.

// File: rtl/bridge_seq.sv
module bridge_seq #(
  parameter int          HOLD_CYCLES = 32,
  parameter int          ACK_WAIT    = 250,
  parameter logic [31:0] ID_VALUE    = 32'h6272_6467
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        island_up,
  input  logic        req_enable,
  input  logic        req_disable,
  input  logic        req_reset,
  input  logic        mst_ack,
  input  logic        slv_ack,
  output logic        clk_en_o,
  output logic        blk_rst_n_o,
  output logic        mst_stop_o,
  output logic        slv_stop_o,
  output logic        busy_o,
  output logic        done_o,
  output logic        err_o,
  output logic        rst_status_o,
  output logic [31:0] id_o
);
  localparam int CMAX = (HOLD_CYCLES > ACK_WAIT) ? HOLD_CYCLES : ACK_WAIT;
  localparam int CW   = $clog2(CMAX + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_HOLD, S_REL, S_CLKON, S_MGO, S_MWAIT, S_SWAIT, S_MUNDO,
    S_DSWAIT, S_DMWAIT, S_DSUNDO, S_DFIN, S_RESTART
  } st_t;

  st_t           st;
  logic [CW-1:0] cnt;
  logic          again;

  wire hold_end = (cnt == CW'(HOLD_CYCLES - 1));
  wire tmo      = (cnt == CW'(ACK_WAIT - 1));

  assign busy_o       = (st != S_IDLE);
  assign rst_status_o = ~blk_rst_n_o;
  assign id_o         = ID_VALUE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= S_IDLE;
      cnt         <= '0;
      again       <= 1'b0;
      clk_en_o    <= 1'b0;
      blk_rst_n_o <= 1'b0;
      mst_stop_o  <= 1'b1;
      slv_stop_o  <= 1'b1;
      done_o      <= 1'b0;
      err_o       <= 1'b0;
    end else begin
      done_o <= 1'b0;
      err_o  <= 1'b0;
      unique case (st)
        S_IDLE: begin
          cnt   <= '0;
          again <= 1'b0;
          if (req_reset) begin
            if (island_up) begin
              again      <= 1'b1;
              slv_stop_o <= 1'b1;
              st         <= S_DSWAIT;
            end else begin
              err_o <= 1'b1;
            end
          end else if (req_disable) begin
            slv_stop_o <= 1'b1;
            st         <= S_DSWAIT;
          end else if (req_enable) begin
            clk_en_o <= 1'b1;
            st       <= S_HOLD;
          end
        end
        S_HOLD: begin
          if (hold_end) begin
            clk_en_o <= 1'b0;
            st       <= S_REL;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_REL: begin
          blk_rst_n_o <= 1'b1;
          st          <= S_CLKON;
        end
        S_CLKON: begin
          clk_en_o <= 1'b1;
          st       <= S_MGO;
        end
        S_MGO: begin
          mst_stop_o <= 1'b0;
          cnt        <= '0;
          st         <= S_MWAIT;
        end
        S_MWAIT: begin
          if (!mst_ack) begin
            slv_stop_o <= 1'b0;
            cnt        <= '0;
            st         <= S_SWAIT;
          end else if (tmo) begin
            clk_en_o    <= 1'b0;
            blk_rst_n_o <= 1'b0;
            err_o       <= 1'b1;
            st          <= S_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_SWAIT: begin
          if (!slv_ack) begin
            done_o <= 1'b1;
            st     <= S_IDLE;
          end else if (tmo) begin
            mst_stop_o <= 1'b1;
            cnt        <= '0;
            st         <= S_MUNDO;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_MUNDO: begin
          if (mst_ack || tmo) begin
            clk_en_o    <= 1'b0;
            blk_rst_n_o <= 1'b0;
            err_o       <= 1'b1;
            st          <= S_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_DSWAIT: begin
          if (slv_ack) begin
            mst_stop_o <= 1'b1;
            cnt        <= '0;
            st         <= S_DMWAIT;
          end else if (tmo) begin
            err_o <= 1'b1;
            st    <= S_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_DMWAIT: begin
          if (mst_ack) begin
            clk_en_o <= 1'b0;
            st       <= S_DFIN;
          end else if (tmo) begin
            slv_stop_o <= 1'b0;
            cnt        <= '0;
            st         <= S_DSUNDO;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_DSUNDO: begin
          if (!slv_ack || tmo) begin
            err_o <= 1'b1;
            st    <= S_IDLE;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        S_DFIN: begin
          blk_rst_n_o <= 1'b0;
          if (again) begin
            st <= S_RESTART;
          end else begin
            done_o <= 1'b1;
            st     <= S_IDLE;
          end
        end
        S_RESTART: begin
          clk_en_o <= 1'b1;
          cnt      <= '0;
          st       <= S_HOLD;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // R2
  mst_start_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mst_stop_o) |-> (clk_en_o && blk_rst_n_o));

  // R3
  rel_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(blk_rst_n_o) |-> !clk_en_o);

  // R6
  rst_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(blk_rst_n_o) |-> !clk_en_o);

  // R10
  island_refuse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && req_reset && !island_up) |=>
      (err_o && !busy_o && $stable(clk_en_o) && $stable(blk_rst_n_o)));

  // R11
  result_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done_o, err_o}));

  // R11
  result_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o || err_o) |-> !busy_o);
endmodule

// File: tb/test_bridge_seq.sv
`timescale 1ns/1ps
module test_bridge_seq;
  localparam int HOLD = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic island_up = 1'b1;
  logic req_enable = 1'b0, req_disable = 1'b0, req_reset = 1'b0;
  logic m_ack = 1'b1, s_ack = 1'b1;
  logic clk_en, blk_rst_n, mst_stop, slv_stop, busy, done, err, rst_status;
  logic [31:0] id;

  int total = 0;
  int bad = 0;
  int m_lat = 1, s_lat = 1;
  logic m_stuck = 1'b0, s_stuck = 1'b0;
  int m_cnt = 0, s_cnt = 0;

  always #2 clk = ~clk;

  bridge_seq #(.HOLD_CYCLES(HOLD)) i_bridge_seq (
    .clk(clk), .rst_n(rst_n), .island_up(island_up),
    .req_enable(req_enable), .req_disable(req_disable), .req_reset(req_reset),
    .mst_ack(m_ack), .slv_ack(s_ack),
    .clk_en_o(clk_en), .blk_rst_n_o(blk_rst_n), .mst_stop_o(mst_stop),
    .slv_stop_o(slv_stop), .busy_o(busy), .done_o(done), .err_o(err),
    .rst_status_o(rst_status), .id_o(id));

  // bridge responders: acknowledge follows stop request after a latency
  always @(negedge clk) begin
    if (!m_stuck && m_ack != mst_stop) begin
      if (m_cnt >= m_lat) begin m_ack <= mst_stop; m_cnt <= 0; end
      else m_cnt <= m_cnt + 1;
    end else m_cnt <= 0;
    if (!s_stuck && s_ack != slv_stop) begin
      if (s_cnt >= s_lat) begin s_ack <= slv_stop; s_cnt <= 0; end
      else s_cnt <= s_cnt + 1;
    end else s_cnt <= 0;
  end

  typedef struct packed {
    logic [1:0] op;     // 1 enable, 2 disable, 3 reset pulse
    logic       isl;
    logic [3:0] ml;
    logic [3:0] sl;
    logic       ms;
    logic       ss;
    logic       eerr;
    logic [3:0] eout;   // {clk_en, rst_n, mst_stop, slv_stop}
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{2'd1, 1'b1, 4'd2, 4'd3, 1'b0, 1'b0, 1'b0, 4'b1100},
    '{2'd2, 1'b1, 4'd1, 4'd1, 1'b0, 1'b0, 1'b0, 4'b0011},
    '{2'd1, 1'b1, 4'd5, 4'd7, 1'b0, 1'b0, 1'b0, 4'b1100},
    '{2'd3, 1'b1, 4'd3, 4'd3, 1'b0, 1'b0, 1'b0, 4'b1100},
    '{2'd2, 1'b1, 4'd1, 4'd1, 1'b0, 1'b1, 1'b1, 4'b1101},
    '{2'd2, 1'b1, 4'd1, 4'd1, 1'b1, 1'b0, 1'b1, 4'b1110},
    '{2'd2, 1'b1, 4'd1, 4'd1, 1'b0, 1'b0, 1'b0, 4'b0011},
    '{2'd1, 1'b1, 4'd1, 4'd1, 1'b1, 1'b0, 1'b1, 4'b0001},
    '{2'd1, 1'b1, 4'd1, 4'd1, 1'b0, 1'b0, 1'b0, 4'b1100},
    '{2'd2, 1'b1, 4'd1, 4'd1, 1'b0, 1'b0, 1'b0, 4'b0011},
    '{2'd1, 1'b1, 4'd1, 4'd1, 1'b0, 1'b1, 1'b1, 4'b0010},
    '{2'd1, 1'b1, 4'd1, 4'd1, 1'b0, 1'b0, 1'b0, 4'b1100},
    '{2'd3, 1'b0, 4'd1, 4'd1, 1'b0, 1'b0, 1'b1, 4'b1100}
  };

  function automatic string tag_of(input int i);
    case (i)
      1, 6, 9: return "R6";
      3:       return "R9";
      4:       return "R7";
      5:       return "R8";
      7:       return "R4";
      10:      return "R5";
      12:      return "R10";
      default: return "R2";
    endcase
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic issue(input logic e, input logic d, input logic r);
    @(negedge clk);
    req_enable = e; req_disable = d; req_reset = r;
    @(negedge clk);
    req_enable = 1'b0; req_disable = 1'b0; req_reset = 1'b0;
  endtask

  task automatic wait_result();
    for (int i = 0; i < 3000; i++) begin
      if (done || err) break;
      @(negedge clk);
    end
  endtask

  initial begin
    #600000;
    bad++;
    total++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int hold_len, m_i, s_i, dones, extra;
    logic clk_at_rel, seen_rel, seen_low, seen_clk_off, in_hold;
    repeat (3) @(negedge clk);
    // R1
    chk("R1", "outputs after reset", {28'd0, clk_en, blk_rst_n, mst_stop, slv_stop}, 32'h3);
    chk("R1", "busy/rst_status after reset", {30'd0, busy, rst_status}, 32'h1);
    chk("R12", "id word", id, 32'h6272_6467);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      m_lat = int'(VECS[v].ml); s_lat = int'(VECS[v].sl);
      m_stuck = VECS[v].ms; s_stuck = VECS[v].ss;
      island_up = VECS[v].isl;
      issue(VECS[v].op == 2'd1, VECS[v].op == 2'd2, VECS[v].op == 2'd3);
      wait_result();
      chk(tag_of(v), "result {done,err}", {30'd0, done, err}, {30'd0, ~VECS[v].eerr, VECS[v].eerr});
      chk(tag_of(v), "controls {clk,rst_n,mstop,sstop}",
          {28'd0, clk_en, blk_rst_n, mst_stop, slv_stop}, {28'd0, VECS[v].eout});
      @(negedge clk);
    end
    m_stuck = 1'b0; s_stuck = 1'b0; island_up = 1'b1; m_lat = 1; s_lat = 1;
    repeat (4) @(negedge clk);

    // R11: coincident enable and disable in idle, disable wins
    issue(1'b1, 1'b1, 1'b0);
    wait_result();
    chk("R11", "priority disable over enable", {27'd0, done, clk_en, blk_rst_n, mst_stop, slv_stop}, 32'h13);
    repeat (3) @(negedge clk);
    chk("R12", "rst_status while held", {31'd0, rst_status}, 32'h1);

    // R2/R3/R11: monitored enable, with requests thrown in while busy
    @(negedge clk);
    req_enable = 1'b1;
    @(negedge clk);
    req_enable = 1'b0;
    hold_len = 0; m_i = -1; s_i = -1; seen_rel = 1'b0; clk_at_rel = 1'b1; in_hold = 1'b1;
    for (int i = 0; i < 3000; i++) begin
      if (done || err) break;
      if (in_hold) begin
        if (clk_en) hold_len++;
        else in_hold = 1'b0;
      end
      if (!seen_rel && blk_rst_n) begin seen_rel = 1'b1; clk_at_rel = clk_en; end
      if (m_i < 0 && !mst_stop) m_i = i;
      if (s_i < 0 && !slv_stop) s_i = i;
      @(negedge clk);
      if (i == 4) begin req_disable = 1'b1; req_reset = 1'b1; end
      if (i == 5) begin req_disable = 1'b0; req_reset = 1'b0; end
    end
    chk("R2", "clock hold window", hold_len, HOLD);
    chk("R3", "clock at reset release", {31'd0, clk_at_rel}, 32'h0);
    chk("R2", "master started before slave", {31'd0, (m_i >= 0) && (s_i > m_i)}, 32'h1);
    chk("R11", "enable done while requests ignored", {27'd0, done, clk_en, blk_rst_n, mst_stop, slv_stop}, 32'h1C);
    extra = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (busy || done || err) extra++;
    end
    chk("R11", "no activity from ignored requests", extra, 0);
    chk("R12", "rst_status while released", {31'd0, rst_status}, 32'h0);

    // R9: reset pulse passes through reset and a gated clock, single done
    issue(1'b0, 1'b0, 1'b1);
    dones = 0; seen_low = 1'b0; seen_clk_off = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      if (!blk_rst_n) seen_low = 1'b1;
      if (!clk_en) seen_clk_off = 1'b1;
      if (done) dones++;
      if (done || err) break;
      @(negedge clk);
    end
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (done || err) dones++;
    end
    chk("R9", "reset asserted and clock gated during pulse", {30'd0, seen_low, seen_clk_off}, 32'h3);
    chk("R9", "single completion", dones, 1);
    chk("R9", "controls after pulse", {28'd0, clk_en, blk_rst_n, mst_stop, slv_stop}, 32'hC);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule